// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day as a count of whole seconds and a count of 1/256 second fractions. It runs from a slow reference clock. A fixed divider turns every 128 reference cycles into one advance of the fraction count, and each wrap of the fraction carries into the seconds count.

Software sets the time, sets an alarm time and reads both through a small register bus. When the counter steps onto the alarm time, a sticky flag is set. The interrupt output is that flag gated by an enable bit. The block uses only its own clock and reset, so it keeps counting in every low-power state. Its interrupt output can therefore serve as the wake-up request.

Register addresses: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control (bit 0 is the interrupt enable), 5 status (bit 0 is the alarm flag). All other addresses read as zero.

Top module: `tod_clock`

## Requirements
- R1: After reset or after a time-register write, the time advances exactly once every 128 clock cycles and holds its value in between.
- R2: Each advance increments the fraction by one. The fraction is 8 bits in bits 7:0 of address 1. Bits 31:8 read as zero, and written bits 31:8 are discarded.
- R3: When the fraction wraps from 255 to 0, the seconds count (address 0) increments in the same advance. Seconds wrap from 0xFFFFFFFF to 0.
- R4: A write to address 0 or address 1 loads that count at the write edge and restarts the divider, so the next advance falls 128 cycles after the write.
- R5: Read data appears on bus_rdata one cycle after the read and holds until the next read. A read of address 0 captures the fraction at the same edge, and a read of address 1 returns that captured value.
- R6: The status flag (address 5, bit 0) is set at the advance that moves the time onto the alarm value held at addresses 2 and 3. A write that puts the time equal to the alarm does not set the flag.
- R7: The flag stays set until a write of 1 to bit 0 of address 5 clears it. Writing 0 there has no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: alarm_irq is high exactly when the flag and the enable (address 4, bit 0) are both 1. The flag still sets while the enable is 0.
- R9: After reset every register is 0, bus_rdata is 0 and alarm_irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| alarm_irq | output | 1 | Alarm interrupt and wake-up request |

## Verification
The assertions assume a reset at the start and at most one register access per cycle. They also assume the time registers change only through the counter or a bus write to addresses 0 and 1. The bench respects these assumptions. It asserts reset before any access and drives each access for one cycle from a falling edge. It leaves idle cycles between accesses, and it places one status clear on the same edge as an alarm match to exercise the set-over-clear case.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int TOD_SEC_W  = 32;
    localparam int TOD_FRAC_W = 8;

    typedef struct packed {
        logic [TOD_SEC_W-1:0]  sec;
        logic [TOD_FRAC_W-1:0] frac;
    } tod_time_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } presc_st_t;

    presc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            tick     = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: two advances are never back to back
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_sec,
    input  logic              wr_frac,
    input  logic [DATA_W-1:0] wdata,
    output tod_time_t         now,
    output tod_time_t         nxt,
    output logic              adv
);
    tod_time_t t_d, t_q;
    logic      carry;

    always_comb begin
        t_d   = t_q;
        carry = 1'b0;
        adv   = tick && !wr_sec && !wr_frac;
        if (wr_sec)  t_d.sec  = wdata[TOD_SEC_W-1:0];
        if (wr_frac) t_d.frac = wdata[TOD_FRAC_W-1:0];
        if (adv) begin
            {carry, t_d.frac} = {1'b0, t_q.frac} + 1'b1;
            t_d.sec = t_q.sec + TOD_SEC_W'(carry);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign now = t_q;
    assign nxt = t_d;

    // R2: an advance moves the fraction on by exactly one
    assert_frac_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_sec && !wr_frac) |=> t_q.frac == TOD_FRAC_W'($past(t_q.frac) + 1));
    // R3: a fraction wrap carries into seconds
    assert_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_sec && !wr_frac && t_q.frac == '1) |=>
            (t_q.frac == '0 && t_q.sec == TOD_SEC_W'($past(t_q.sec) + 1)));
    // R1: time holds between advances
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_sec && !wr_frac) |=> $stable(t_q));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  tod_time_t         nxt,
    input  logic              wr_alm_sec,
    input  logic              wr_alm_frac,
    input  logic              wr_ctrl,
    input  logic              wr_stat,
    input  logic [DATA_W-1:0] wdata,
    output tod_time_t         alm,
    output logic              en,
    output logic              flag,
    output logic              irq
);
    typedef struct packed {
        tod_time_t alm;
        logic      en;
        logic      flag;
    } alm_st_t;

    alm_st_t st_d, st_q;
    logic    match;
    logic    clr;

    always_comb begin
        st_d  = st_q;
        match = adv && (nxt == st_q.alm);
        clr   = wr_stat && wdata[0];
        if (wr_alm_sec)  st_d.alm.sec  = wdata[TOD_SEC_W-1:0];
        if (wr_alm_frac) st_d.alm.frac = wdata[TOD_FRAC_W-1:0];
        if (wr_ctrl)     st_d.en       = wdata[0];
        st_d.flag = match || (st_q.flag && !clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alm  = st_q.alm;
    assign en   = st_q.en;
    assign flag = st_q.flag;
    assign irq  = st_q.flag && st_q.en;

    // R7: the flag stays set unless a clear is written
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(wr_stat && wdata[0])) |=> st_q.flag);
    // R6: the flag rises only after a counter advance
    assert_rise_on_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(adv));
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int DIV    = 128,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              alarm_irq
);
    localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_FRAC  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_ASEC  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_AFRAC = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(5);

    typedef struct packed {
        logic [TOD_FRAC_W-1:0] snap;
        logic [DATA_W-1:0]     rdata;
    } top_st_t;

    top_st_t   st_d, st_q;
    logic      wr, rd, wr_sec, wr_frac, tick, adv, en, flag;
    tod_time_t now, nxt, alm;
    logic [DATA_W-1:0] rmux;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign wr_sec  = wr && bus_addr == A_SEC;
    assign wr_frac = wr && bus_addr == A_FRAC;

    tod_prescaler #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(wr_sec || wr_frac), .tick(tick));

    tod_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_sec(wr_sec), .wr_frac(wr_frac),
        .wdata(bus_wdata), .now(now), .nxt(nxt), .adv(adv));

    tod_alarm #(.DATA_W(DATA_W)) u_alm (
        .clk(clk), .rst_n(rst_n), .adv(adv), .nxt(nxt),
        .wr_alm_sec(wr && bus_addr == A_ASEC), .wr_alm_frac(wr && bus_addr == A_AFRAC),
        .wr_ctrl(wr && bus_addr == A_CTRL), .wr_stat(wr && bus_addr == A_STAT),
        .wdata(bus_wdata), .alm(alm), .en(en), .flag(flag), .irq(alarm_irq));

    always_comb begin
        st_d = st_q;
        case (bus_addr)
            A_SEC:   rmux = DATA_W'(now.sec);
            A_FRAC:  rmux = DATA_W'(st_q.snap);
            A_ASEC:  rmux = DATA_W'(alm.sec);
            A_AFRAC: rmux = DATA_W'(alm.frac);
            A_CTRL:  rmux = DATA_W'(en);
            A_STAT:  rmux = DATA_W'(flag);
            default: rmux = '0;
        endcase
        if (rd) begin
            st_d.rdata = rmux;
            if (bus_addr == A_SEC) st_d.snap = now.frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R2: a fraction read never shows upper bits
    assert_frac_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == A_FRAC) |=> bus_rdata[DATA_W-1:TOD_FRAC_W] == '0);
    // R5: read data holds when no read is made
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tod_clock u_tod_clock (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alarm_irq(alarm_irq));

    // behavioural reference model
    logic [31:0] m_sec, m_asec, m_rdata;
    logic [7:0]  m_frac, m_afrac, m_snap;
    logic        m_en, m_flag;
    int          m_presc;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_frac = 0; m_asec = 0; m_afrac = 0; m_snap = 0;
            m_rdata = 0; m_en = 0; m_flag = 0; m_presc = 0;
        end else begin
            bit match, clr, wsec, wfrac;
            match = 0;
            wsec  = bus_sel && bus_we && bus_addr == 0;
            wfrac = bus_sel && bus_we && bus_addr == 1;
            if (bus_sel && !bus_we) begin
                case (bus_addr)
                    0: m_rdata = m_sec;
                    1: m_rdata = {24'h0, m_snap};
                    2: m_rdata = m_asec;
                    3: m_rdata = {24'h0, m_afrac};
                    4: m_rdata = {31'h0, m_en};
                    5: m_rdata = {31'h0, m_flag};
                    default: m_rdata = 0;
                endcase
                if (bus_addr == 0) m_snap = m_frac;
            end
            if (wsec || wfrac) begin
                if (wsec)  m_sec  = bus_wdata;
                if (wfrac) m_frac = bus_wdata[7:0];
                m_presc = 0;
            end else if (m_presc == 127) begin
                m_presc = 0;
                if (m_frac == 8'hFF) m_sec = m_sec + 1;
                m_frac = m_frac + 1;
                match = (m_sec == m_asec) && (m_frac == m_afrac);
            end else begin
                m_presc++;
            end
            clr = bus_sel && bus_we && bus_addr == 5 && bus_wdata[0];
            if (bus_sel && bus_we && bus_addr == 2) m_asec = bus_wdata;
            if (bus_sel && bus_we && bus_addr == 3) m_afrac = bus_wdata[7:0];
            if (bus_sel && bus_we && bus_addr == 4) m_en = bus_wdata[0];
            m_flag = match ? 1'b1 : (clr ? 1'b0 : m_flag);
        end
        #5;
        if (rst_n && !done) begin
            chk("R8 irq vs model", {31'h0, alarm_irq}, {31'h0, m_flag && m_en});
            chk("R5 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R9 reset rdata", bus_rdata, 0);
        chk("R9 reset irq", {31'h0, alarm_irq}, 0);
        rst_n = 1;
        rd(0, v); chk("R9 reset seconds", v, 0);
        rd(5, v); chk("R9 reset flag", v, 0);

        // free run: three advances
        idle(128 * 3 + 20);
        rd(0, v); chk("R1 seconds after free run", v, 0);
        rd(1, v); chk("R1 R2 fraction after three advances", v, 3);

        // carry
        wr(1, 32'd254); wr(0, 32'd10);
        idle(128 * 3 + 10);
        rd(0, v); chk("R3 seconds after carry", v, 11);
        rd(1, v); chk("R3 fraction after wrap", v, 1);

        // seconds wrap and upper fraction bits discarded
        wr(1, 32'h1234_56FF); wr(0, 32'hFFFF_FFFF);
        rd(0, v); rd(1, v); chk("R2 upper bits discarded", v, 32'hFF);
        idle(128 + 5);
        rd(0, v); chk("R3 seconds wrap", v, 0);
        rd(1, v); chk("R3 fraction wrap to zero", v, 0);

        // prescaler restart on write
        idle(60);
        wr(1, 32'd5);
        idle(120);
        rd(0, v); rd(1, v); chk("R4 no advance before 128 cycles", v, 5);
        idle(10);
        rd(0, v); rd(1, v); chk("R4 advance after restart", v, 6);

        // snapshot coherence
        rd(0, v);
        idle(140);
        rd(1, v); chk("R5 fraction read returns snapshot", v, 6);

        // alarm with enable clear
        wr(2, 32'd100); wr(3, 32'd2);
        wr(1, 32'd0); wr(0, 32'd100);
        idle(300);
        rd(5, v); chk("R6 flag set at alarm", v, 1);
        chk("R8 irq gated by enable", {31'h0, alarm_irq}, 0);
        wr(4, 32'd1);
        @(negedge clk); chk("R8 irq with enable", {31'h0, alarm_irq}, 1);
        wr(5, 32'd0);
        rd(5, v); chk("R7 write 0 keeps flag", v, 1);
        wr(5, 32'd1);
        rd(5, v); chk("R7 write 1 clears flag", v, 0);
        chk("R8 irq low after clear", {31'h0, alarm_irq}, 0);

        // write equal to alarm does not set flag
        wr(2, 32'd200); wr(3, 32'd7);
        wr(1, 32'd7); wr(0, 32'd200);
        idle(20);
        rd(5, v); chk("R6 write onto alarm leaves flag clear", v, 0);

        // set and clear on the same edge
        wr(2, 32'd300); wr(3, 32'd1);
        wr(1, 32'd0); wr(0, 32'd300);
        idle(126);
        wr(5, 32'd1);
        rd(5, v); chk("R7 set wins over clear", v, 1);

        idle(10);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule